// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block takes a bank of maskable interrupt request lines and decides which of them the processor should service next. Every channel has an enable bit, a pending bit, an active bit and a priority of sixteen levels. All of these are set up over a small write/read register port. Among the channels that are enabled, pending and more urgent than the handler now running, the block picks one. It presents that channel's vector address together with an entry request to the processor.

The processor acknowledges the request to begin the handler and signals an exit when the handler returns. Until the acknowledge arrives, the presented vector follows the most urgent eligible channel, so a request that comes in late and is more urgent takes over the entry. The block keeps a stack of the levels that were preempted. On an exit it evaluates the pending channels against the level that is uncovered, so the next handler can be requested in the very next cycle without first going back to the idle level.

Top module: `pvic`

## Requirements
- R1: After reset, entry_req is 0, cur_level is 16 (no handler running), the vector base is 0, and every channel reads back as all zero.
- R2: A write with reg_we=1 applies reg_op to channel reg_ch: 0 sets enable, 1 clears enable, 2 sets pending, 3 clears pending, 4 loads priority from reg_wdata[3:0], and 5 loads the vector base from reg_wdata for any reg_ch. reg_rdata returns {active, pending, enable, priority[3:0]} of reg_ch in bits 6:0.
- R3: An irq bit that is high at a clock edge sets that channel's pending bit. A pending bit sets the channel's pending read-back bit whether or not the channel is enabled.
- R4: A channel is eligible when it is enabled, pending, and its priority is numerically below cur_level. entry_req goes high on the second clock edge after an irq pulse. entry_vec equals base + (16 + channel) × 4 for the eligible channel with the lowest priority value, and a tie goes to the lower channel number.
- R5: While entry_req is high and no acknowledge has been given, a more urgent request that arrives later replaces the presented vector. The channel that was displaced stays pending.
- R6: An edge with entry_req and entry_ack both high enters the presented channel. Its pending bit clears, its active bit sets, cur_level becomes its priority, and entry_req is low in the following cycle.
- R7: A pending channel whose priority equals the running level is not requested. Only a strictly more urgent priority preempts.
- R8: An edge with entry_exit high clears the active bit of the running handler and restores the previous level. When an eligible channel exists against that restored level, entry_req is high right after that same edge, which is tail-chaining.
- R9: Handlers nest up to 16 deep. Each exit restores the levels in reverse order, and an exit with no handler running has no effect.
- R10: A disabled channel is never requested even when it is pending. Enabling it later produces the request, and clearing its pending bit before entry withdraws the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 60 | Interrupt request lines, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_op | input | 3 | Register operation code |
| reg_ch | input | 6 | Channel addressed by the register port |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the addressed channel |
| entry_req | output | 1 | Request to enter a handler |
| entry_vec | output | 32 | Vector address of the presented channel |
| entry_ack | input | 1 | Processor accepts the presented entry |
| entry_exit | input | 1 | Processor leaves the running handler |
| cur_level | output | 5 | Priority of the running handler, 16 when none |

## Verification
The hardest situation to reach is a sixteen-deep nest followed by a chain of exits. In that chain every exit must uncover the correct level and the read-back must show the right active bits. The bench reaches it by giving sixteen channels priorities that fall from 15 to 0 and acknowledging each of them in turn while the one before is still running, so the stack fills completely. Late arrival and tail-chaining are reached by sending a second, more urgent request while the first is still unacknowledged, then checking the request line right after each exit, before any idle cycle can occur.

// File: rtl/pvic.sv
module pvic #(
  parameter int NCH   = 60,
  parameter int PW    = 4,
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(NCH),
  localparam int LW   = PW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] irq,
  input  logic           reg_we,
  input  logic [2:0]     reg_op,
  input  logic [CW-1:0]  reg_ch,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata,
  output logic           entry_req,
  output logic [AW-1:0]  entry_vec,
  input  logic           entry_ack,
  input  logic           entry_exit,
  output logic [LW-1:0]  cur_level
);
  localparam int NLEV = 1 << PW;
  localparam int SPW  = $clog2(DEPTH + 1);
  localparam int IW   = $clog2(DEPTH);

  logic [NCH-1:0] enable, pending, active, pend_n;
  logic [PW-1:0]  prio [NCH];
  logic [AW-1:0]  vec_base;
  logic [CW-1:0]  stk_ch [DEPTH];
  logic [PW-1:0]  stk_pr [DEPTH];
  logic [SPW-1:0] sp;
  logic           sel_vld;
  logic [CW-1:0]  sel_ch;
  logic           best_vld;
  logic [CW-1:0]  best_ch;
  logic [PW-1:0]  best_pr;
  logic [LW-1:0]  lvl_below, thr;

  wire            ch_ok = 32'(reg_ch) < NCH;
  wire            wr_ok = reg_we & ch_ok;
  wire            take  = sel_vld & entry_ack;
  wire            pop   = entry_exit & (sp != '0) & ~take;
  wire [IW-1:0]   i_top = IW'(sp - SPW'(1));
  wire [IW-1:0]   i_low = IW'(sp - SPW'(2));

  assign cur_level = (sp == '0) ? LW'(NLEV) : {1'b0, stk_pr[i_top]};
  assign lvl_below = (sp < SPW'(2)) ? LW'(NLEV) : {1'b0, stk_pr[i_low]};
  assign thr       = pop ? lvl_below : cur_level;
  assign entry_req = sel_vld;
  assign entry_vec = vec_base + ((AW'(sel_ch) + AW'(16)) << 2);
  assign reg_rdata = ch_ok ? AW'({active[reg_ch], pending[reg_ch], enable[reg_ch], prio[reg_ch]}) : '0;

  always_comb begin
    best_vld = 1'b0;
    best_ch  = '0;
    best_pr  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (enable[i] && pending[i] && ({1'b0, prio[i]} < thr) &&
          (!best_vld || prio[i] < best_pr)) begin
        best_vld = 1'b1;
        best_ch  = CW'(i);
        best_pr  = prio[i];
      end
    end
  end

  always_comb begin
    pend_n = pending;
    if (take) pend_n[sel_ch] = 1'b0;
    pend_n = pend_n | irq;
    if (wr_ok && reg_op == 3'd2) pend_n[reg_ch] = 1'b1;
    if (wr_ok && reg_op == 3'd3) pend_n[reg_ch] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable   <= '0;
      pending  <= '0;
      active   <= '0;
      vec_base <= '0;
      sp       <= '0;
      sel_vld  <= 1'b0;
      sel_ch   <= '0;
      for (int i = 0; i < NCH; i++) prio[i] <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stk_ch[i] <= '0;
        stk_pr[i] <= '0;
      end
    end else begin
      pending <= pend_n;
      sel_vld <= take ? 1'b0 : best_vld;
      sel_ch  <= best_ch;
      if (reg_we && reg_op == 3'd5) vec_base <= reg_wdata;
      if (wr_ok) begin
        case (reg_op)
          3'd0:    enable[reg_ch] <= 1'b1;
          3'd1:    enable[reg_ch] <= 1'b0;
          3'd4:    prio[reg_ch]   <= reg_wdata[PW-1:0];
          default: ;
        endcase
      end
      if (take && sp < SPW'(DEPTH)) begin
        active[sel_ch]        <= 1'b1;
        stk_ch[sp[IW-1:0]]    <= sel_ch;
        stk_pr[sp[IW-1:0]]    <= prio[sel_ch];
        sp                    <= sp + SPW'(1);
      end
      if (pop) begin
        active[stk_ch[i_top]] <= 1'b0;
        sp                    <= sp - SPW'(1);
      end
    end
  end
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
  parameter int NCH = 60,
  parameter int PW  = 4,
  parameter int AW  = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          entry_req,
  input logic          entry_ack,
  input logic          entry_exit,
  input logic [PW:0]   cur_level,
  input logic [AW-1:0] entry_vec,
  input logic [AW-1:0] vec_base
);
  localparam int NLEV = 1 << PW;
  logic [AW-1:0] off;
  assign off = entry_vec - vec_base;

  a_r6_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_req && entry_ack) |=> !entry_req);
  a_r6_level_deepens: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_req && entry_ack) |=> cur_level < $past(cur_level));
  a_r8_exit_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_exit && !(entry_req && entry_ack) && cur_level != (PW+1)'(NLEV)) |=> cur_level > $past(cur_level));
  a_r9_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_exit && !entry_req && cur_level == (PW+1)'(NLEV)) |=> cur_level == (PW+1)'(NLEV));
  a_r9_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level <= (PW+1)'(NLEV));
  a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |-> (off >= AW'(64) && off <= AW'(64 + 4 * (NCH - 1)) && off[1:0] == 2'b00));
endmodule

bind pvic pvic_chk #(.NCH(NCH), .PW(PW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .entry_ack(entry_ack),
  .entry_exit(entry_exit), .cur_level(cur_level), .entry_vec(entry_vec),
  .vec_base(vec_base));

// File: tb/pvic_test.sv
module pvic_test;
  localparam int NCH = 60;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] irq = '0;
  logic reg_we = 1'b0, entry_ack = 1'b0, entry_exit = 1'b0;
  logic [2:0] reg_op = '0;
  logic [5:0] reg_ch = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, entry_vec;
  logic entry_req;
  logic [4:0] cur_level;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pvic uut (.clk(clk), .rst_n(rst_n), .irq(irq), .reg_we(reg_we), .reg_op(reg_op),
    .reg_ch(reg_ch), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .entry_req(entry_req),
    .entry_vec(entry_vec), .entry_ack(entry_ack), .entry_exit(entry_exit), .cur_level(cur_level));

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(int op, int ch, logic [31:0] d);
    reg_we = 1'b1; reg_op = 3'(op); reg_ch = 6'(ch); reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic pulse(int ch);
    irq[ch] = 1'b1; tick(); irq[ch] = 1'b0; tick();
  endtask

  task automatic ack(); entry_ack = 1'b1; tick(); entry_ack = 1'b0; endtask
  task automatic ex();  entry_exit = 1'b1; tick(); entry_exit = 1'b0; endtask

  function automatic logic [31:0] vec(int ch); return BASE + 32'((16 + ch) * 4); endfunction

  function automatic logic [31:0] rd(int a, int p, int e, int pr);
    return 32'((a << 6) | (p << 5) | (e << 4) | pr);
  endfunction

  task automatic peek(int ch); reg_ch = 6'(ch); #1; endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 req", 32'(entry_req), 0);
    chk("R1 level", 32'(cur_level), 16);
    peek(7); chk("R1 rdata", reg_rdata, 0);
    chk("R1 base", entry_vec, 32'd64);

    wr(5, 0, BASE);
    for (int c = 0; c < NCH; c++) begin
      wr(0, c, 0); wr(4, c, 32'(c % 16));
      pulse(c);
      chk("R4 sweep req", 32'(entry_req), 1);
      chk("R4 sweep vec", entry_vec, vec(c));
      ack();
      chk("R6 req low", 32'(entry_req), 0);
      chk("R6 level", 32'(cur_level), 32'(c % 16));
      peek(c); chk("R6 rdata", reg_rdata, rd(1, 0, 1, c % 16));
      ex();
      chk("R8 level back", 32'(cur_level), 16);
      peek(c); chk("R8 active clr", reg_rdata, rd(0, 0, 1, c % 16));
      wr(1, c, 0);
      peek(c); chk("R2 en clr", reg_rdata, rd(0, 0, 0, c % 16));
    end

    for (int k = 0; k < 4; k++) begin
      int bc, bp;
      bc = 0; bp = 99;
      for (int c = 0; c < NCH; c++) begin
        int p;
        p = (c * (2 * k + 3) + 5 * k + 1) % 16;
        wr(4, c, 32'(p)); wr(0, c, 0); wr(2, c, 0);
        if (p < bp) begin bp = p; bc = c; end
      end
      tick();
      chk("R4 arb req", 32'(entry_req), 1);
      chk("R4 arb vec", entry_vec, vec(bc));
      peek(bc); chk("R2 rdata", reg_rdata, rd(0, 1, 1, bp));
      for (int c = 0; c < NCH; c++) begin wr(3, c, 0); wr(1, c, 0); end
      tick();
      chk("R2 pend clr", 32'(entry_req), 0);
    end

    wr(4, 33, 5); wr(4, 21, 5); wr(0, 33, 0); wr(0, 21, 0);
    wr(2, 33, 0); wr(2, 21, 0); tick();
    chk("R4 tie", entry_vec, vec(21));
    ack(); ex(); chk("R8 chain tie", entry_vec, vec(33));
    ack(); ex(); tick();
    wr(1, 21, 0); wr(1, 33, 0);

    wr(4, 10, 8); wr(0, 10, 0); wr(4, 40, 2); wr(0, 40, 0); wr(4, 20, 2); wr(0, 20, 0);
    pulse(10);
    chk("R3 req", 32'(entry_req), 1);
    chk("R3 vec", entry_vec, vec(10));
    pulse(40);
    chk("R5 late vec", entry_vec, vec(40));
    ack();
    chk("R5 level", 32'(cur_level), 2);
    peek(10); chk("R5 still pending", reg_rdata, rd(0, 1, 1, 8));
    pulse(20); tick();
    chk("R7 equal no req", 32'(entry_req), 0);
    ex();
    chk("R8 tail req", 32'(entry_req), 1);
    chk("R8 tail vec", entry_vec, vec(20));
    ack();
    chk("R6 level", 32'(cur_level), 2);
    ex();
    chk("R8 tail2 vec", entry_vec, vec(10));
    ack();
    chk("R6 level", 32'(cur_level), 8);
    ex(); tick();
    chk("R8 idle", 32'(entry_req), 0);
    chk("R8 idle level", 32'(cur_level), 16);
    wr(1, 10, 0); wr(1, 20, 0); wr(1, 40, 0);

    for (int c = 0; c < 16; c++) begin wr(4, c, 32'(15 - c)); wr(0, c, 0); end
    for (int c = 0; c < 16; c++) begin
      pulse(c);
      chk("R7 preempt req", 32'(entry_req), 1);
      chk("R7 preempt vec", entry_vec, vec(c));
      ack();
      chk("R9 nest level", 32'(cur_level), 32'(15 - c));
    end
    peek(0); chk("R9 deep active", reg_rdata, rd(1, 0, 1, 15));
    for (int c = 15; c >= 0; c--) begin
      ex();
      chk("R9 unwind", 32'(cur_level), (c == 0) ? 32'd16 : 32'(16 - c));
      peek(c); chk("R9 active clr", reg_rdata, rd(0, 0, 1, 15 - c));
    end
    ex(); tick();
    chk("R9 empty exit", 32'(cur_level), 16);
    chk("R9 empty req", 32'(entry_req), 0);
    for (int c = 0; c < 16; c++) wr(1, c, 0);

    wr(4, 50, 0); pulse(50); tick();
    chk("R10 disabled", 32'(entry_req), 0);
    peek(50); chk("R3 pend no en", reg_rdata, rd(0, 1, 0, 0));
    wr(0, 50, 0); tick();
    chk("R10 enable req", 32'(entry_req), 1);
    chk("R10 enable vec", entry_vec, vec(50));
    wr(3, 50, 0); tick();
    chk("R10 withdrawn", 32'(entry_req), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule